// File: doc/BRIEF.md
# Readout Snapshot Spy Recorder

This block sits beside a data-block builder and takes a one-shot copy of one complete block into an internal RAM. It never stalls the builder. The builder's own cycle-start, word-valid, abort and done strobes drive it. Each valid word is written at the address given by the builder's word index. A host arms a capture with a rising edge on a command level. The capture always begins at the next block start, so a block that is already running is never recorded.

When a captured block completes, the recorder disarms itself. It sets a full flag and raises a one-cycle interrupt pulse. If the captured block is aborted, the recorder stays armed and records the next block instead. The host reads the copy while holding a read-enable level. Each increment strobe advances the read address by one word. The word at the current read address is presented on the data output. Releasing the read-enable level rewinds the read address and clears the full flag, which allows a new capture to be armed. Reading all the way through the RAM also clears the flag.

All outputs are registered except the read data in the default configuration. A registered output changes on the clock edge that samples its cause. The default read data follows the read address in the same cycle.

Top module: `snap_spy`

## Requirements
- R1: A rising edge on `arm_cmd` arms one capture. The capture starts only at a `blk_start` sampled in a later cycle than that edge. A block already in progress when the edge arrives is not recorded, and its `blk_done` has no effect.
- R2: A `blk_done` during a capture ends the capture and disarms the recorder. On the next edge `spy_full` goes to 1 and `spy_irq` is 1 for exactly that one cycle. `spy_full` rises only in this way.
- R3: A `blk_abort` during a capture leaves `spy_full` and `spy_irq` at 0 and keeps the recorder armed. The next block is then captured. If abort and done arrive together, abort wins.
- R4: A falling edge of `rd_en` sets `rd_addr` to 0 and clears `spy_full` on that edge. A `blk_done` that completes a capture in the same cycle wins, and `spy_full` is set.
- R5: While `rd_en` is 1, a sampled `rd_inc` advances `rd_addr` by one on that edge, wrapping modulo 2^ADDR_W. The increment that wraps the address from its last value to 0 clears `spy_full`. Otherwise `rd_addr` holds.
- R6: A rising edge on `arm_cmd` while `spy_full` is 1 is ignored. No further block is recorded until `spy_full` has been cleared by releasing `rd_en` (R4) or by a full wrap (R5).
- R7: A word presented with `wr_valid` during a capture, in the cycles after its `blk_start` up to and including the cycle of `blk_done` or `blk_abort`, is stored at RAM address `wr_index`. `rd_data` shows the RAM word at `rd_addr` in the same cycle.
- R8: A sampled `init` returns the recorder to the disarmed state and clears `spy_full`, `spy_irq` and `rd_addr` on that edge.
- R9: After reset, `spy_full` and `spy_irq` are 0 and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous clear of arming, capture, full flag and read address |
| arm_cmd | input | 1 | Host capture command level; its rising edge arms one capture |
| blk_start | input | 1 | Builder cycle-start strobe |
| wr_valid | input | 1 | Builder word-valid strobe |
| wr_index | input | ADDR_W | Builder word index, used as the RAM write address |
| wr_data | input | DATA_W | Builder word |
| blk_abort | input | 1 | Builder cycle aborted |
| blk_done | input | 1 | Builder cycle completed successfully |
| rd_en | input | 1 | Host read-enable level; its falling edge rewinds the read address |
| rd_inc | input | 1 | Host read-address increment strobe |
| rd_data | output | DATA_W | RAM word at the read address |
| rd_addr | output | ADDR_W | Current RAM read address |
| spy_full | output | 1 | A complete block is held and has not yet been released |
| spy_irq | output | 1 | One-cycle interrupt pulse when `spy_full` rises |

## Verification
The assertions check the read-address arithmetic on every cycle: each step, hold, rewind on release, and clear on init. They also check that the interrupt is a single pulse coinciding with the rise of the full flag, and that this rise is always caused by a done strobe. The arming rules cannot be seen from one cycle at the ports. These are the deferral past a running block, the automatic re-arm after an abort, and the refusal of an arm edge while full. They show up only in the bench's block sequences, through the cycle-by-cycle reference model and the stored words read back.

// File: rtl/snap_spy_pkg.sv
package snap_spy_pkg;
   typedef enum logic [1:0] {
      SPY_IDLE  = 2'd0,
      SPY_ARMED = 2'd1,
      SPY_CAPT  = 2'd2
   } spy_state_e;
endpackage

// File: rtl/snap_spy_edge.sv
module snap_spy_edge #(
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   generate
      if (FALLING) begin : g_fall
         assign pulse = lvl_q & ~lvl;
      end else begin : g_rise
         assign pulse = lvl & ~lvl_q;
      end
   endgenerate
endmodule

// File: rtl/snap_spy_ctrl.sv
module snap_spy_ctrl
   import snap_spy_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic arm_rise,
   input  logic blk_start,
   input  logic blk_abort,
   input  logic blk_done,
   input  logic full_clr,
   output logic capturing,
   output logic spy_full,
   output logic spy_irq
);
   spy_state_e st_q, st_n;
   logic       full_set;

   always_comb begin
      st_n     = st_q;
      full_set = 1'b0;
      unique case (st_q)
         SPY_IDLE:  if (arm_rise && !spy_full) st_n = SPY_ARMED;
         SPY_ARMED: if (blk_start) st_n = SPY_CAPT;
         SPY_CAPT: begin
            if (blk_abort) begin
               st_n = SPY_ARMED;
            end else if (blk_done) begin
               st_n     = SPY_IDLE;
               full_set = 1'b1;
            end
         end
         default: st_n = SPY_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SPY_IDLE;
         spy_full <= 1'b0;
         spy_irq  <= 1'b0;
      end else if (init) begin
         st_q     <= SPY_IDLE;
         spy_full <= 1'b0;
         spy_irq  <= 1'b0;
      end else begin
         st_q     <= st_n;
         spy_full <= full_set ? 1'b1 : (full_clr ? 1'b0 : spy_full);
         spy_irq  <= full_set;
      end
   end

   assign capturing = (st_q == SPY_CAPT);
endmodule

// File: rtl/snap_spy_rdptr.sv
module snap_spy_rdptr #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              rd_en,
   input  logic              rd_inc,
   input  logic              rd_fall,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wrap
);
   localparam logic [ADDR_W-1:0] LAST = '1;

   logic step;
   assign step = rd_en & rd_inc;
   assign wrap = step & (rd_addr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rd_addr <= '0;
      else if (init || rd_fall)  rd_addr <= '0;
      else if (step)             rd_addr <= rd_addr + 1'b1;
   end
endmodule

// File: rtl/snap_spy_ram.sv
module snap_spy_ram #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/snap_spy.sv
module snap_spy #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              arm_cmd,
   input  logic              blk_start,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_index,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              blk_abort,
   input  logic              blk_done,
   input  logic              rd_en,
   input  logic              rd_inc,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              spy_full,
   output logic              spy_irq
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("snap_spy: DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("snap_spy: ADDR_W must lie in 1..16");
      end
   endgenerate

   logic arm_rise, rd_fall, wrap, capturing, full_clr, ram_we;

   snap_spy_edge #(.FALLING(1'b0)) u_arm_edge (
      .clk(clk), .rst_n(rst_n), .lvl(arm_cmd), .pulse(arm_rise)
   );

   snap_spy_edge #(.FALLING(1'b1)) u_rd_edge (
      .clk(clk), .rst_n(rst_n), .lvl(rd_en), .pulse(rd_fall)
   );

   snap_spy_rdptr #(.ADDR_W(ADDR_W)) u_rdptr (
      .clk(clk), .rst_n(rst_n), .init(init), .rd_en(rd_en), .rd_inc(rd_inc),
      .rd_fall(rd_fall), .rd_addr(rd_addr), .wrap(wrap)
   );

   assign full_clr = rd_fall | wrap;

   snap_spy_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .init(init), .arm_rise(arm_rise),
      .blk_start(blk_start), .blk_abort(blk_abort), .blk_done(blk_done),
      .full_clr(full_clr), .capturing(capturing), .spy_full(spy_full),
      .spy_irq(spy_irq)
   );

   assign ram_we = capturing & wr_valid;

   snap_spy_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_REG(RD_REG)) u_ram (
      .clk(clk), .we(ram_we), .waddr(wr_index), .wdata(wr_data),
      .raddr(rd_addr), .rdata(rd_data)
   );
endmodule

// File: rtl/snap_spy_chk.sv
module snap_spy_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init,
   input logic              rd_en,
   input logic              rd_inc,
   input logic              blk_done,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              spy_full,
   input logic              spy_irq
);
   // R2
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spy_irq |=> !spy_irq);

   // R2
   irq_on_full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spy_irq |-> (spy_full && !$past(spy_full)));

   // R2
   full_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spy_full) |-> $past(blk_done));

   // R4
   release_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && $past(rd_en) && !blk_done) |=> (rd_addr == '0 && !spy_full));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_inc && !init) |=> (rd_addr == $past(rd_addr) + 1'b1));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !(rd_en && rd_inc) && !(!rd_en && $past(rd_en))) |=> $stable(rd_addr));

   // R8
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (!spy_full && !spy_irq && rd_addr == '0));
endmodule

bind snap_spy snap_spy_chk #(.ADDR_W(ADDR_W)) u_snap_spy_chk (.*);

// File: tb/snap_spy_bench.sv
module snap_spy_bench;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 12;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              init = 1'b0, arm_cmd = 1'b0, blk_start = 1'b0, wr_valid = 1'b0;
   logic [ADDR_W-1:0] wr_index = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              blk_abort = 1'b0, blk_done = 1'b0, rd_en = 1'b0, rd_inc = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] rd_addr;
   logic              spy_full, spy_irq;

   always #(CLK_P/2) clk = ~clk;

   snap_spy #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_snap_spy (
      .clk(clk), .rst_n(rst_n), .init(init), .arm_cmd(arm_cmd), .blk_start(blk_start),
      .wr_valid(wr_valid), .wr_index(wr_index), .wr_data(wr_data),
      .blk_abort(blk_abort), .blk_done(blk_done), .rd_en(rd_en), .rd_inc(rd_inc),
      .rd_data(rd_data), .rd_addr(rd_addr), .spy_full(spy_full), .spy_irq(spy_irq)
   );

   int n_chk = 0, n_bad = 0;
   bit ended = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // Behavioural reference model: 0 idle, 1 armed, 2 capturing
   int              m_state = 0;
   bit              m_full = 0, m_irq = 0, m_arm_q = 0, m_rd_q = 0;
   int              m_ptr = 0;
   logic [DATA_W-1:0] m_mem [int];
   bit              m_rise, m_fall, m_set, m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_full = 0; m_irq = 0; m_arm_q = 0; m_rd_q = 0; m_ptr = 0;
      end else begin
         m_rise = arm_cmd && !m_arm_q;
         m_fall = m_rd_q && !rd_en;
         m_arm_q = arm_cmd;
         m_rd_q  = rd_en;
         if (m_state == 2 && wr_valid) m_mem[int'(wr_index)] = wr_data;
         if (init) begin
            m_state = 0; m_full = 0; m_irq = 0; m_ptr = 0;
         end else begin
            m_set = 0; m_clr = 0;
            if (m_state == 0) begin
               if (m_rise && !m_full) m_state = 1;
            end else if (m_state == 1) begin
               if (blk_start) m_state = 2;
            end else begin
               if (blk_abort) m_state = 1;
               else if (blk_done) begin m_state = 0; m_set = 1; end
            end
            if (m_fall) begin
               m_ptr = 0; m_clr = 1;
            end else if (rd_en && rd_inc) begin
               if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_clr = 1; end
               else m_ptr = m_ptr + 1;
            end
            m_full = m_set ? 1'b1 : (m_clr ? 1'b0 : m_full);
            m_irq  = m_set;
         end
      end
   end

   // Cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         chk(spy_full == m_full, "R2", "model spy_full", spy_full, m_full);
         chk(spy_irq == m_irq, "R2", "model spy_irq", spy_irq, m_irq);
         chk(int'(rd_addr) == m_ptr, "R5", "model rd_addr", rd_addr, m_ptr);
         if (m_mem.exists(m_ptr))
            chk(rd_data == m_mem[m_ptr], "R7", "model rd_data", rd_data, m_mem[m_ptr]);
      end
   end

   function automatic logic [DATA_W-1:0] pat(input int seed, input int i);
      return DATA_W'((seed * 40503 + i * 2654435) ^ (i << 5) ^ seed);
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_arm();
      arm_cmd = 1'b1; tick(); arm_cmd = 1'b0; tick();
   endtask

   task automatic run_block(input int n, input int seed, input bit rev,
                            input bit abrt, input int arm_at);
      blk_start = 1'b1; tick(); blk_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         wr_valid = 1'b1;
         wr_index = ADDR_W'(rev ? (n - 1 - i) : i);
         wr_data  = pat(seed, i);
         arm_cmd  = (i == arm_at);
         tick();
      end
      wr_valid = 1'b0; arm_cmd = 1'b0;
      if (abrt) blk_abort = 1'b1; else blk_done = 1'b1;
      tick();
      blk_abort = 1'b0; blk_done = 1'b0;
   endtask

   task automatic read_back(input int n, input int seed, input bit rev, input string req);
      rd_en = 1'b1; tick();
      for (int a = 0; a < n; a++) begin
         chk(rd_data == pat(seed, rev ? (n - 1 - a) : a), req, "read word", rd_data,
             pat(seed, rev ? (n - 1 - a) : a));
         chk(int'(rd_addr) == (a % DEPTH), "R5", "read address", rd_addr, a % DEPTH);
         rd_inc = 1'b1; tick();
      end
      rd_inc = 1'b0;
   endtask

   initial begin
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      // R9 reset state
      chk(spy_full == 1'b0, "R9", "spy_full after reset", spy_full, 0);
      chk(spy_irq == 1'b0, "R9", "spy_irq after reset", spy_irq, 0);
      chk(rd_addr == '0, "R9", "rd_addr after reset", rd_addr, 0);

      // R1: arm during a running block; that block is not recorded
      run_block(32, 1, 1'b0, 1'b0, 10);
      chk(spy_full == 1'b0, "R1", "full after running block", spy_full, 0);
      tick();
      // R2/R7: next block captured, written in reverse index order
      run_block(40, 2, 1'b1, 1'b0, -1);
      chk(spy_full == 1'b1, "R2", "full after captured block", spy_full, 1);
      chk(spy_irq == 1'b1, "R2", "irq on capture end", spy_irq, 1);
      tick();
      chk(spy_irq == 1'b0, "R2", "irq one cycle only", spy_irq, 0);
      read_back(40, 2, 1'b1, "R7");

      // R6: arm while full ignored, then release
      pulse_arm();
      rd_en = 1'b0; tick();
      chk(rd_addr == '0, "R4", "rd_addr after release", rd_addr, 0);
      chk(spy_full == 1'b0, "R4", "full after release", spy_full, 0);
      run_block(16, 3, 1'b0, 1'b0, -1);
      chk(spy_full == 1'b0, "R6", "arm while full was ignored", spy_full, 0);

      // R3: aborted capture re-arms for the next block
      pulse_arm();
      run_block(20, 4, 1'b0, 1'b1, -1);
      chk(spy_full == 1'b0, "R3", "full after abort", spy_full, 0);
      chk(spy_irq == 1'b0, "R3", "irq after abort", spy_irq, 0);
      tick();
      run_block(24, 5, 1'b0, 1'b0, -1);
      chk(spy_full == 1'b1, "R3", "full after block following abort", spy_full, 1);
      read_back(10, 5, 1'b0, "R3");
      // R4: partial read then release
      rd_en = 1'b0; tick();
      chk(rd_addr == '0, "R4", "rd_addr after partial read", rd_addr, 0);
      chk(spy_full == 1'b0, "R4", "full after partial read", spy_full, 0);

      // R5: full-depth capture and wrap of the read address
      pulse_arm();
      run_block(DEPTH, 6, 1'b0, 1'b0, -1);
      chk(spy_full == 1'b1, "R2", "full after full-depth block", spy_full, 1);
      read_back(DEPTH, 6, 1'b0, "R7");
      chk(rd_addr == '0, "R5", "rd_addr after wrap", rd_addr, 0);
      chk(spy_full == 1'b0, "R5", "full cleared by wrap", spy_full, 0);
      rd_en = 1'b0; tick();

      // R8: init drops a pending arm
      pulse_arm();
      init = 1'b1; tick(); init = 1'b0;
      run_block(12, 7, 1'b0, 1'b0, -1);
      chk(spy_full == 1'b0, "R8", "arm cleared by init", spy_full, 0);
      // R8: init clears full and read address
      pulse_arm();
      run_block(12, 8, 1'b0, 1'b0, -1);
      chk(spy_full == 1'b1, "R2", "full before init", spy_full, 1);
      rd_en = 1'b1; tick();
      rd_inc = 1'b1; repeat (3) tick(); rd_inc = 1'b0;
      chk(rd_addr == ADDR_W'(3), "R5", "rd_addr after three steps", rd_addr, 3);
      init = 1'b1; tick(); init = 1'b0;
      chk(spy_full == 1'b0, "R8", "full after init", spy_full, 0);
      chk(rd_addr == '0, "R8", "rd_addr after init", rd_addr, 0);
      rd_en = 1'b0; tick(); tick();

      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end
endmodule